// File: doc/BRIEF.md
# Overhead Growth Byte Change Monitor

This block handles the three growth bytes of a SONET/SDH frame: two section growth bytes and one line growth byte. On the transmit side it drives three byte values that software can program; each has a fixed value after reset. Locating these bytes inside the frame is done elsewhere. This block only sees them as values.

On the receive side, the framer supplies one strobe per frame together with the three received bytes. Each byte passes through its own persistence filter. A new value is copied into the receive register only after it has been seen on three consecutive frames. Whenever a filter latches a value that differs from what its receive register held, a shared sticky change bit is set. The interrupt output is that bit gated by an enable. While loss of signal or out of frame is flagged, received bytes are ignored, and every filter starts its count again once framing returns.

Software reaches all of this through a small register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `ovh_growth_mon`

## Requirements
- R1: After reset the transmit bytes are 0x02 (section A, address 0), 0x03 (section B, address 1) and 0x00 (line, address 2). The receive registers (addresses 3, 4, 5), the control register (address 6) and the status register (address 7) read 0x00, and `irq` is low.
- R2: A write to address 0, 1 or 2 changes the matching transmit output on the next clock edge, and reading that address returns the written value.
- R3: A received section growth byte is copied into its receive register (address 3 or 4) on the edge of the third consecutive `frame_stb` that carries the same value. Before that edge the register keeps its old value.
- R4: The received line growth byte uses the same three-frame rule before it is copied into address 5.
- R5: A strobe whose byte differs from the value being counted restarts that byte's count at one, so an interrupted run does not latch.
- R6: While `los` or `oof` is high, strobes change no receive register, and the counts are cleared. After framing returns, three fresh matching strobes are needed before a value latches.
- R7: When a filter latches a value that differs from its receive register, bit 0 of the status register (address 7) is set. A value that persists but equals the register content sets nothing.
- R8: Status bit 0 stays set until software writes 1 to bit 0 of address 7. Writing 0 leaves it set. If a change occurs in the same cycle as a clear, the bit stays set.
- R9: `irq` equals status bit 0 ANDed with control bit 0 (address 6). It follows a change of the enable without waiting for a new event.
- R10: Software can write the receive registers at addresses 3, 4 and 5, and reading them back returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One pulse per frame; the receive bytes are valid with it |
| los | input | 1 | Loss of signal, suppresses receive updates |
| oof | input | 1 | Out of frame, suppresses receive updates |
| rx_sec_grw_a | input | 8 | Received section growth byte A |
| rx_sec_grw_b | input | 8 | Received section growth byte B |
| rx_line_grw | input | 8 | Received line growth byte |
| tx_sec_grw_a | output | 8 | Transmit section growth byte A |
| tx_sec_grw_b | output | 8 | Transmit section growth byte B |
| tx_line_grw | output | 8 | Transmit line growth byte |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Change interrupt |

## Verification
A latch event from a persistence filter and a software clear of the sticky status bit can land on the same clock edge. The bench provokes this by sending two matching frames and then driving the third strobe in the same cycle as a write of 1 to the status register. It then expects the status bit and `irq` to remain set and the new byte to be latched, because a set must win over the clear. A second overlap, a receive-register write arriving against a filter that keeps running, is judged by reading back the written value before the next strobe.

// File: rtl/ovh_growth_pkg.sv
package ovh_growth_pkg;
   localparam int GRW_NUM     = 3;
   localparam int ADR_TX_BASE = 0;
   localparam int ADR_RX_BASE = 3;
   localparam int ADR_CTRL    = 6;
   localparam int ADR_STAT    = 7;
endpackage

// File: rtl/ovh_persist_filter.sv
module ovh_persist_filter #(
   parameter int W       = 8,
   parameter int PERSIST = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_stb,
   input  logic         hold,
   input  logic [W-1:0] rx_in,
   input  logic         sw_wr,
   input  logic [W-1:0] sw_data,
   output logic [W-1:0] lat_o,
   output logic         change_o
);
   localparam int CNT_W = $clog2(PERSIST + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PERSIST);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic [W-1:0]     cand_q, lat_q;
   logic             fire;

   always_comb begin
      if (cnt_q == '0 || rx_in != cand_q)
         cnt_nx = CNT_ONE;
      else if (cnt_q == CNT_TOP)
         cnt_nx = cnt_q;
      else
         cnt_nx = cnt_q + CNT_ONE;
   end

   assign fire = frame_stb & ~hold & (cnt_nx == CNT_TOP) & (rx_in != lat_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cand_q <= '0;
      end else if (hold) begin
         cnt_q  <= '0;
      end else if (frame_stb) begin
         cnt_q  <= cnt_nx;
         cand_q <= rx_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= '0;
      else if (fire)   lat_q <= rx_in;
      else if (sw_wr)  lat_q <= sw_data;
   end

   assign lat_o    = lat_q;
   assign change_o = fire;
endmodule

// File: rtl/ovh_grw_ctrl.sv
module ovh_grw_ctrl
   import ovh_growth_pkg::*;
#(
   parameter int W      = 8,
   parameter int NB     = 3,
   parameter int ADDR_W = 3,
   parameter logic [NB-1:0][W-1:0] TX_DEF = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [W-1:0]         wdata,
   input  logic                 evt,
   output logic [NB-1:0][W-1:0] tx_q,
   output logic                 en_q,
   output logic                 stat_q
);
   logic clr;
   assign clr = wr && addr == ADDR_W'(ADR_STAT) && wdata[0];

   for (genvar i = 0; i < NB; i++) begin : g_tx
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tx_q[i] <= TX_DEF[i];
         else if (wr && addr == ADDR_W'(ADR_TX_BASE + i))
            tx_q[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         stat_q <= 1'b0;
      end else begin
         if (wr && addr == ADDR_W'(ADR_CTRL)) en_q <= wdata[0];
         stat_q <= evt | (stat_q & ~clr);
      end
   end
endmodule

// File: rtl/ovh_growth_mon.sv
module ovh_growth_mon
   import ovh_growth_pkg::*;
#(
   parameter int W       = 8,
   parameter int PERSIST = 3,
   parameter int ADDR_W  = 3,
   parameter logic [W-1:0] TX_DEF_A = 8'h02,
   parameter logic [W-1:0] TX_DEF_B = 8'h03,
   parameter logic [W-1:0] TX_DEF_L = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              los,
   input  logic              oof,
   input  logic [W-1:0]      rx_sec_grw_a,
   input  logic [W-1:0]      rx_sec_grw_b,
   input  logic [W-1:0]      rx_line_grw,
   output logic [W-1:0]      tx_sec_grw_a,
   output logic [W-1:0]      tx_sec_grw_b,
   output logic [W-1:0]      tx_line_grw,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [W-1:0]      cpu_wdata,
   output logic [W-1:0]      cpu_rdata,
   output logic              irq
);
   localparam int NB = GRW_NUM;
   localparam logic [NB-1:0][W-1:0] TX_DEF = {TX_DEF_L, TX_DEF_B, TX_DEF_A};

   if (PERSIST < 2) begin : g_bad_persist
      $error("PERSIST must be at least 2");
   end
   if ((1 << ADDR_W) <= ADR_STAT) begin : g_bad_addr
      $error("ADDR_W too narrow for register map");
   end

   logic [NB-1:0][W-1:0] rx_in, rx_lat, tx_q;
   logic [NB-1:0]        chg;
   logic                 en_q, stat_q, hold;

   assign rx_in = {rx_line_grw, rx_sec_grw_b, rx_sec_grw_a};
   assign hold  = los | oof;

   for (genvar i = 0; i < NB; i++) begin : g_flt
      ovh_persist_filter #(.W(W), .PERSIST(PERSIST)) flt_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .frame_stb(frame_stb),
         .hold     (hold),
         .rx_in    (rx_in[i]),
         .sw_wr    (cpu_wr && cpu_addr == ADDR_W'(ADR_RX_BASE + i)),
         .sw_data  (cpu_wdata),
         .lat_o    (rx_lat[i]),
         .change_o (chg[i])
      );
   end

   ovh_grw_ctrl #(.W(W), .NB(NB), .ADDR_W(ADDR_W), .TX_DEF(TX_DEF)) ctrl_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cpu_wr),
      .addr  (cpu_addr),
      .wdata (cpu_wdata),
      .evt   (|chg),
      .tx_q  (tx_q),
      .en_q  (en_q),
      .stat_q(stat_q)
   );

   assign tx_sec_grw_a = tx_q[0];
   assign tx_sec_grw_b = tx_q[1];
   assign tx_line_grw  = tx_q[2];
   assign irq          = stat_q & en_q;

   always_comb begin
      cpu_rdata = '0;
      for (int i = 0; i < NB; i++) begin
         if (cpu_addr == ADDR_W'(ADR_TX_BASE + i)) cpu_rdata = tx_q[i];
         if (cpu_addr == ADDR_W'(ADR_RX_BASE + i)) cpu_rdata = rx_lat[i];
      end
      if (cpu_addr == ADDR_W'(ADR_CTRL)) cpu_rdata = W'(en_q);
      if (cpu_addr == ADDR_W'(ADR_STAT)) cpu_rdata = W'(stat_q);
   end
endmodule

// File: rtl/ovh_growth_mon_chk.sv
module ovh_growth_mon_chk
   import ovh_growth_pkg::*;
#(
   parameter int W      = 8,
   parameter int NB     = 3,
   parameter int ADDR_W = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 frame_stb,
   input logic                 los,
   input logic                 oof,
   input logic                 cpu_wr,
   input logic [ADDR_W-1:0]    cpu_addr,
   input logic [W-1:0]         cpu_wdata,
   input logic [NB-1:0][W-1:0] rx_in,
   input logic [NB-1:0][W-1:0] rx_lat,
   input logic [NB-1:0]        chg,
   input logic                 stat_q
);
   assert_alarm_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((los || oof) && !cpu_wr) |=> $stable(rx_lat));

   assert_no_strobe_no_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_stb && !cpu_wr) |=> $stable(rx_lat));

   for (genvar i = 0; i < NB; i++) begin : g_ev
      assert_event_is_new_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
         chg[i] |-> (rx_in[i] != rx_lat[i]) && frame_stb && !los && !oof);
   end

   assert_event_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|chg) |=> stat_q);

   assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q && !(cpu_wr && cpu_addr == ADDR_W'(ADR_STAT) && cpu_wdata[0])) |=> stat_q);
endmodule

bind ovh_growth_mon ovh_growth_mon_chk #(.W(W), .NB(NB), .ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .frame_stb(frame_stb),
   .los      (los),
   .oof      (oof),
   .cpu_wr   (cpu_wr),
   .cpu_addr (cpu_addr),
   .cpu_wdata(cpu_wdata),
   .rx_in    (rx_in),
   .rx_lat   (rx_lat),
   .chg      (chg),
   .stat_q   (stat_q)
);

// File: tb/ovh_growth_mon_tb_top.sv
`timescale 1ns/100ps
module ovh_growth_mon_tb_top;
   localparam real CLK_PERIOD = 10.0;

   typedef struct {
      int       sel;   // 0..7 register, 8..10 tx outputs, 11 irq
      logic [7:0] exp;
      string    req;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic frame_stb = 0, los = 0, oof = 0, cpu_wr = 0, irq;
   logic [7:0] rxa = 0, rxb = 0, rxl = 0, txa, txb, txl, wdata = 0, rdata;
   logic [2:0] wr_addr = 0, rd_addr = 0, cpu_addr;

   item_t q[$];
   int pending = 0, n_chk = 0, n_fail = 0;
   bit done = 0;
   event smp;

   assign cpu_addr = cpu_wr ? wr_addr : rd_addr;
   always #(CLK_PERIOD / 2) clk = ~clk;

   ovh_growth_mon dut_i (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .los(los), .oof(oof),
      .rx_sec_grw_a(rxa), .rx_sec_grw_b(rxb), .rx_line_grw(rxl),
      .tx_sec_grw_a(txa), .tx_sec_grw_b(txb), .tx_line_grw(txl),
      .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(wdata),
      .cpu_rdata(rdata), .irq(irq));

   // monitor: pops expected items and compares against the design
   initial begin
      forever begin
         @(smp);
         while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            if (it.sel < 8) rd_addr = 3'(it.sel);
            #0.2;
            case (it.sel)
               8:  act = txa;
               9:  act = txb;
               10: act = txl;
               11: act = {7'd0, irq};
               default: act = rdata;
            endcase
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
            pending--;
         end
      end
   end

   task automatic expect_v(input int sel, input logic [7:0] exp, input string req);
      item_t it;
      it.sel = sel; it.exp = exp; it.req = req;
      q.push_back(it);
      pending++;
   endtask

   task automatic judge();
      -> smp;
      wait (pending == 0);
   endtask

   task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_wr = 1; wr_addr = a; wdata = d;
      @(negedge clk);
      cpu_wr = 0;
   endtask

   task automatic frame(input logic [7:0] a, b, l, input bit lo = 0, input bit of = 0,
                        input bit clr = 0);
      @(negedge clk);
      frame_stb = 1; rxa = a; rxb = b; rxl = l; los = lo; oof = of;
      if (clr) begin cpu_wr = 1; wr_addr = 3'd7; wdata = 8'h01; end
      @(negedge clk);
      frame_stb = 0; los = 0; oof = 0; cpu_wr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      expect_v(0, 8'h02, "R1"); expect_v(1, 8'h03, "R1"); expect_v(2, 8'h00, "R1");
      expect_v(3, 8'h00, "R1"); expect_v(4, 8'h00, "R1"); expect_v(5, 8'h00, "R1");
      expect_v(6, 8'h00, "R1"); expect_v(7, 8'h00, "R1");
      expect_v(8, 8'h02, "R1"); expect_v(9, 8'h03, "R1"); expect_v(10, 8'h00, "R1");
      expect_v(11, 8'h00, "R1");
      judge();
      // R2 transmit programming
      cpu_write(3'd0, 8'h5A); cpu_write(3'd2, 8'hC3);
      expect_v(8, 8'h5A, "R2"); expect_v(10, 8'hC3, "R2"); expect_v(9, 8'h03, "R2");
      expect_v(0, 8'h5A, "R2"); expect_v(2, 8'hC3, "R2");
      judge();
      // R3 / R7 / R9 section byte A latches on third frame
      cpu_write(3'd6, 8'h01);
      frame(8'h11, 8'h00, 8'h00); frame(8'h11, 8'h00, 8'h00);
      expect_v(3, 8'h00, "R3"); expect_v(7, 8'h00, "R7"); expect_v(11, 8'h00, "R9");
      judge();
      frame(8'h11, 8'h00, 8'h00);
      expect_v(3, 8'h11, "R3"); expect_v(7, 8'h01, "R7"); expect_v(11, 8'h01, "R9");
      judge();
      // R8 clear by writing 1
      cpu_write(3'd7, 8'h01);
      expect_v(7, 8'h00, "R8"); expect_v(11, 8'h00, "R8");
      judge();
      // R4 line byte
      frame(8'h11, 8'h00, 8'h7E); frame(8'h11, 8'h00, 8'h7E);
      expect_v(5, 8'h00, "R4"); expect_v(7, 8'h00, "R4");
      judge();
      frame(8'h11, 8'h00, 8'h7E);
      expect_v(5, 8'h7E, "R4"); expect_v(7, 8'h01, "R4"); expect_v(3, 8'h11, "R4");
      judge();
      cpu_write(3'd7, 8'h01);
      // R5 interrupted run on byte B
      frame(8'h11, 8'h44, 8'h7E); frame(8'h11, 8'h44, 8'h7E);
      frame(8'h11, 8'h45, 8'h7E);
      frame(8'h11, 8'h44, 8'h7E); frame(8'h11, 8'h44, 8'h7E);
      expect_v(4, 8'h00, "R5"); expect_v(7, 8'h00, "R5");
      judge();
      frame(8'h11, 8'h44, 8'h7E);
      expect_v(4, 8'h44, "R5"); expect_v(7, 8'h01, "R5");
      judge();
      // R8 writing 0 keeps it set
      cpu_write(3'd7, 8'h00);
      expect_v(7, 8'h01, "R8");
      judge();
      cpu_write(3'd7, 8'h01);
      // R8 set wins over simultaneous clear
      frame(8'h22, 8'h44, 8'h7E); frame(8'h22, 8'h44, 8'h7E);
      expect_v(7, 8'h00, "R8");
      judge();
      frame(8'h22, 8'h44, 8'h7E, 0, 0, 1);
      expect_v(7, 8'h01, "R8"); expect_v(3, 8'h22, "R8"); expect_v(11, 8'h01, "R8");
      judge();
      // R9 enable gating
      cpu_write(3'd6, 8'h00);
      expect_v(11, 8'h00, "R9"); expect_v(7, 8'h01, "R9");
      judge();
      cpu_write(3'd6, 8'h01);
      expect_v(11, 8'h01, "R9");
      judge();
      cpu_write(3'd7, 8'h01);
      // R6 loss of signal restarts count
      frame(8'h33, 8'h44, 8'h7E); frame(8'h33, 8'h44, 8'h7E);
      frame(8'h33, 8'h44, 8'h7E, 1, 0);
      frame(8'h33, 8'h44, 8'h7E);
      expect_v(3, 8'h22, "R6"); expect_v(7, 8'h00, "R6");
      judge();
      frame(8'h33, 8'h44, 8'h7E);
      expect_v(3, 8'h22, "R6");
      judge();
      frame(8'h33, 8'h44, 8'h7E);
      expect_v(3, 8'h33, "R6"); expect_v(7, 8'h01, "R6");
      judge();
      cpu_write(3'd7, 8'h01);
      // R6 out of frame: strobe ignored and count restarts
      frame(8'h55, 8'h44, 8'h7E); frame(8'h55, 8'h44, 8'h7E);
      frame(8'h55, 8'h44, 8'h7E, 0, 1);
      frame(8'h55, 8'h44, 8'h7E);
      expect_v(3, 8'h33, "R6"); expect_v(7, 8'h00, "R6");
      judge();
      // R7 persisting value equal to register raises nothing
      frame(8'h33, 8'h44, 8'h7E); frame(8'h33, 8'h44, 8'h7E);
      frame(8'h33, 8'h44, 8'h7E); frame(8'h33, 8'h44, 8'h7E);
      expect_v(3, 8'h33, "R7"); expect_v(7, 8'h00, "R7"); expect_v(11, 8'h00, "R7");
      judge();
      // R10 software write of receive registers
      cpu_write(3'd3, 8'h99); cpu_write(3'd4, 8'hA5); cpu_write(3'd5, 8'h0F);
      expect_v(3, 8'h99, "R10"); expect_v(4, 8'hA5, "R10"); expect_v(5, 8'h0F, "R10");
      judge();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule